// File: doc/BRIEF.md
# Banked Address Generator with Pointer Locations

This block builds the 24-bit physical word address that a small processor core presents to memory. The address is the 16-bit word offset with an 8-bit bank number above it. The bank number comes from one of eight bank registers. The microcode tells the block what kind of access is being prepared through a set of decoded enables:

- instruction fetch or local data,
- page-zero data,
- stack,
- indexed through a pointer location.

The block then picks the bank register that belongs to that kind of access. When microcode asks to load the address register, the chosen bank and the offset are captured together.

A band of page-zero locations acts as pointers. Two address bits of such a location choose how the pointer behaves: plain, post-increment, post-decrement, or stack. Its three lowest bits name the bank the pointer refers to. These low bits reach the block as the instruction's low operand bits.

The block classifies each pointer access. It tells the control unit whether to increment or decrement the pointer, and whether the change comes before the access or after it. It also supplies the adjusted 16-bit pointer value, which wraps within the bank. Software reads and writes the bank registers through an I/O-space port.

Top module: `bank_addr_gen`

## Requirements
- R1: During reset, bank register 0 is set to 8'hFF if `rom_present` is high and to 8'h00 if it is low. `addr_out` resets to 0.
- R2: When `en_fetch` is high, the bank register 0 is the selected bank, whatever the other enables are.
- R3: When `en_fetch` is low, `en_zpage` high selects bank register 1. When both of those are low, `en_stack` high selects bank register 2.
- R4: When `en_fetch`, `en_zpage` and `en_stack` are all low, `en_index` high selects the bank register numbered by `ir_lo`. With no enable high, bank register 0 is used.
- R5: On a clock edge with `ar_load` high, `addr_out` becomes {selected bank, `ofs`}, so the new value is visible one cycle after the request. Without `ar_load`, `addr_out` holds its value.
- R6: A clock edge with `io_wr` high writes `io_wdata` into the bank register numbered by `io_sel`. While `io_rd` is high, `io_rdata` shows the bank register numbered by `io_sel` in the same cycle. While `io_rd` is low, `io_rdata` is 0.
- R7: With `ptr_chk` high and `ptr_addr` in 16'h0100–16'h01FF, bits 7:6 of `ptr_addr` decide the pointer behaviour:
  - 2'b00: no adjustment.
  - 2'b01: `ainc`.
  - 2'b10: `adec`.
  - 2'b11 (stack): `ainc` when `ptr_write` is high, with `adj_pre` low. `adec` when `ptr_write` is low, with `adj_pre` high.
- R8: If `ptr_chk` is low, or `ptr_addr` lies outside 16'h0100–16'h01FF (for example 16'h0000–16'h00FF or 16'h0200–16'h03FF), then `ainc`, `adec` and `adj_pre` are low and `ptr_next` equals `ptr_val`.
- R9: When `ainc` is high, `ptr_next` is `ptr_val`+1 modulo 2^16. When `adec` is high, it is `ptr_val`−1 modulo 2^16. The bank is never carried into, so 16'hFFFF steps to 16'h0000 and 16'h0000 steps back to 16'hFFFF.
- R10: `ainc` and `adec` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rom_present | input | 1 | Boot ROM fitted; sets bank 0 reset value |
| en_fetch | input | 1 | Fetch or local-data access enable |
| en_zpage | input | 1 | Page-zero access enable |
| en_stack | input | 1 | Stack access enable |
| en_index | input | 1 | Pointer-indexed access enable |
| ir_lo | input | 3 | Instruction operand low bits naming a bank |
| ofs | input | 16 | Word offset within the bank |
| ar_load | input | 1 | Load request for the address register |
| addr_out | output | 24 | Registered {bank, offset} address |
| io_wr | input | 1 | I/O write strobe for a bank register |
| io_rd | input | 1 | I/O read enable for a bank register |
| io_sel | input | 3 | Bank register number for I/O access |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| ptr_chk | input | 1 | Current access goes through a page-zero pointer location |
| ptr_addr | input | 16 | Page-zero address of that pointer location |
| ptr_write | input | 1 | Access through the pointer is a write |
| ptr_val | input | 16 | Current pointer value |
| ainc | output | 1 | Request to increment the pointer |
| adec | output | 1 | Request to decrement the pointer |
| adj_pre | output | 1 | Adjustment must happen before the access |
| ptr_next | output | 16 | Pointer value after adjustment |

## Verification
A corrupted bank register or a wrong priority decision shows up as a wrong upper byte in `addr_out` one cycle after the next `ar_load`. A bad register is also visible on `io_rdata` in the same cycle it is selected for reading. Classification faults appear combinationally on `ainc`, `adec`, `adj_pre` and `ptr_next` in the cycle the pointer address is presented. The checks therefore focus on:

- the exact boundaries of the pointer band,
- the stack class in both access directions,
- the two wrap points of the pointer arithmetic.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [1:0] {
      PCLS_PLAIN = 2'b00,
      PCLS_INC   = 2'b01,
      PCLS_DEC   = 2'b10,
      PCLS_STACK = 2'b11
   } ptr_class_e;

   localparam int unsigned BAND_PAGE = 1;
endpackage

// File: rtl/bag_bank_file.sv
module bag_bank_file #(
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned SEL_W     = $clog2(NUM_BANKS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              rom_present,
   input  logic                              wr_en,
   input  logic [SEL_W-1:0]                  wr_sel,
   input  logic [BANK_W-1:0]                 wr_data,
   input  logic [SEL_W-1:0]                  rd_sel,
   output logic [BANK_W-1:0]                 rd_data,
   output logic [NUM_BANKS-1:0][BANK_W-1:0]  banks_o
);
   localparam logic [BANK_W-1:0] ROM_BANK = {BANK_W{1'b1}};

   if (NUM_BANKS != (1 << SEL_W)) begin : g_bad_sel
      $error("bag_bank_file: NUM_BANKS must be a power of two matching SEL_W");
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      if (g == 0) begin : g_boot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               banks_o[g] <= rom_present ? ROM_BANK : '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
               banks_o[g] <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               banks_o[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
               banks_o[g] <= wr_data;
         end
      end
   end

   assign rd_data = banks_o[rd_sel];

   p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (banks_o[$past(wr_sel)] == $past(wr_data)));
endmodule

// File: rtl/bag_bank_select.sv
module bag_bank_select #(
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned SEL_W     = $clog2(NUM_BANKS)
) (
   input  logic                              en_fetch,
   input  logic                              en_zpage,
   input  logic                              en_stack,
   input  logic                              en_index,
   input  logic [SEL_W-1:0]                  ir_lo,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0]  banks_i,
   output logic [BANK_W-1:0]                 bank_o
);
   localparam int unsigned FETCH_BANK = 0;
   localparam int unsigned ZPAGE_BANK = 1;
   localparam int unsigned STACK_BANK = 2;

   if (NUM_BANKS <= STACK_BANK) begin : g_bad_count
      $error("bag_bank_select: at least three bank registers are required");
   end

   always_comb begin
      if (en_fetch)
         bank_o = banks_i[FETCH_BANK];
      else if (en_zpage)
         bank_o = banks_i[ZPAGE_BANK];
      else if (en_stack)
         bank_o = banks_i[STACK_BANK];
      else if (en_index)
         bank_o = banks_i[ir_lo];
      else
         bank_o = banks_i[FETCH_BANK];
   end
endmodule

// File: rtl/bag_ptr_classify.sv
module bag_ptr_classify
   import bag_pkg::*;
#(
   parameter int unsigned OFS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_chk,
   input  logic [OFS_W-1:0] ptr_addr,
   input  logic             ptr_write,
   input  logic [OFS_W-1:0] ptr_val,
   output logic             ainc,
   output logic             adec,
   output logic             adj_pre,
   output logic [OFS_W-1:0] ptr_next
);
   localparam int unsigned PAGE_LSB = 8;

   if (OFS_W <= PAGE_LSB) begin : g_bad_width
      $error("bag_ptr_classify: offset must be wider than one page");
   end

   logic       in_band;
   ptr_class_e cls;

   assign in_band = ptr_chk &&
                    (ptr_addr[OFS_W-1:PAGE_LSB] == (OFS_W-PAGE_LSB)'(BAND_PAGE));
   assign cls     = ptr_class_e'(ptr_addr[PAGE_LSB-1:PAGE_LSB-2]);

   always_comb begin
      ainc    = 1'b0;
      adec    = 1'b0;
      adj_pre = 1'b0;
      if (in_band) begin
         unique case (cls)
            PCLS_PLAIN: ;
            PCLS_INC:   ainc = 1'b1;
            PCLS_DEC:   adec = 1'b1;
            PCLS_STACK: begin
               ainc    = ptr_write;
               adec    = !ptr_write;
               adj_pre = !ptr_write;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (ainc)
         ptr_next = ptr_val + OFS_W'(1);
      else if (adec)
         ptr_next = ptr_val - OFS_W'(1);
      else
         ptr_next = ptr_val;
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ainc, adec}));
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_chk |-> (!ainc && !adec && !adj_pre && ptr_next == ptr_val));
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ainc |-> (OFS_W'(ptr_next - ptr_val) == OFS_W'(1)));
   p_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adj_pre |-> (adec && !ptr_write));
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned OFS_W     = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               rom_present,
   input  logic                               en_fetch,
   input  logic                               en_zpage,
   input  logic                               en_stack,
   input  logic                               en_index,
   input  logic [$clog2(NUM_BANKS)-1:0]       ir_lo,
   input  logic [OFS_W-1:0]                   ofs,
   input  logic                               ar_load,
   output logic [BANK_W+OFS_W-1:0]            addr_out,
   input  logic                               io_wr,
   input  logic                               io_rd,
   input  logic [$clog2(NUM_BANKS)-1:0]       io_sel,
   input  logic [BANK_W-1:0]                  io_wdata,
   output logic [BANK_W-1:0]                  io_rdata,
   input  logic                               ptr_chk,
   input  logic [OFS_W-1:0]                   ptr_addr,
   input  logic                               ptr_write,
   input  logic [OFS_W-1:0]                   ptr_val,
   output logic                               ainc,
   output logic                               adec,
   output logic                               adj_pre,
   output logic [OFS_W-1:0]                   ptr_next
);
   localparam int unsigned SEL_W  = $clog2(NUM_BANKS);
   localparam int unsigned ADDR_W = BANK_W + OFS_W;

   if (BANK_W < 1) begin : g_bad_bank
      $error("bank_addr_gen: BANK_W must be positive");
   end

   logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
   logic [BANK_W-1:0]                rd_bank;
   logic [BANK_W-1:0]                sel_bank;

   bag_bank_file #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) i_file (
      .clk         (clk),
      .rst_n       (rst_n),
      .rom_present (rom_present),
      .wr_en       (io_wr),
      .wr_sel      (io_sel),
      .wr_data     (io_wdata),
      .rd_sel      (io_sel),
      .rd_data     (rd_bank),
      .banks_o     (banks)
   );

   bag_bank_select #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) i_sel (
      .en_fetch (en_fetch),
      .en_zpage (en_zpage),
      .en_stack (en_stack),
      .en_index (en_index),
      .ir_lo    (ir_lo),
      .banks_i  (banks),
      .bank_o   (sel_bank)
   );

   bag_ptr_classify #(.OFS_W(OFS_W)) i_cls (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_chk   (ptr_chk),
      .ptr_addr  (ptr_addr),
      .ptr_write (ptr_write),
      .ptr_val   (ptr_val),
      .ainc      (ainc),
      .adec      (adec),
      .adj_pre   (adj_pre),
      .ptr_next  (ptr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_out <= '0;
      else if (ar_load)
         addr_out <= {sel_bank, ofs};
   end

   assign io_rdata = io_rd ? rd_bank : '0;

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ar_load |=> $stable(addr_out));
   p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ar_load |=> (addr_out[OFS_W-1:0] == $past(ofs)));
   p_fetch_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_load && en_fetch && !io_wr) |=> (addr_out[ADDR_W-1:OFS_W] == $past(banks[0])));
   p_quiet_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == '0));
endmodule

// File: tb/test_bank_addr_gen.sv
module test_bank_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rom_present = 1'b1;
   logic        en_fetch = 0, en_zpage = 0, en_stack = 0, en_index = 0;
   logic [2:0]  ir_lo = '0;
   logic [15:0] ofs = '0;
   logic        ar_load = 1'b0;
   logic [23:0] addr_out;
   logic        io_wr = 0, io_rd = 0;
   logic [2:0]  io_sel = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        ptr_chk = 0, ptr_write = 0;
   logic [15:0] ptr_addr = '0, ptr_val = '0;
   logic        ainc, adec, adj_pre;
   logic [15:0] ptr_next;

   int checks = 0;
   int errors = 0;
   logic [23:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  bank_val [8];

   always #4 clk = ~clk;

   bank_addr_gen i_bank_addr_gen (
      .clk, .rst_n, .rom_present, .en_fetch, .en_zpage, .en_stack, .en_index,
      .ir_lo, .ofs, .ar_load, .addr_out, .io_wr, .io_rd, .io_sel, .io_wdata,
      .io_rdata, .ptr_chk, .ptr_addr, .ptr_write, .ptr_val, .ainc, .adec,
      .adj_pre, .ptr_next
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares the captured address against the scoreboard queue
   always @(posedge clk) begin
      if (ar_load && rst_n) begin
         #2;
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5 actual=%h expected=<none queued>", addr_out);
         end else begin
            automatic logic [23:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, 32'(addr_out), 32'(e));
         end
      end
   end

   task automatic do_reset(logic rom);
      @(negedge clk);
      rom_present = rom;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic io_write(int sel, logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; io_sel = 3'(sel); io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0;
      bank_val[sel] = d;
   endtask

   task automatic io_read(int sel, string req);
      @(negedge clk);
      io_rd = 1'b1; io_sel = 3'(sel);
      #1 check(req, 32'(io_rdata), 32'(bank_val[sel]));
      io_rd = 1'b0;
   endtask

   // driver: requests one address load and queues the expected result
   task automatic load(logic f, logic z, logic s, logic x, int ir, logic [15:0] o,
                       int exp_bank, string req);
      @(negedge clk);
      en_fetch = f; en_zpage = z; en_stack = s; en_index = x;
      ir_lo = 3'(ir); ofs = o; ar_load = 1'b1;
      exp_q.push_back({bank_val[exp_bank], o});
      tag_q.push_back(req);
      @(negedge clk);
      ar_load = 1'b0; en_fetch = 0; en_zpage = 0; en_stack = 0; en_index = 0;
   endtask

   task automatic classify(logic chk, logic [15:0] a, logic wr, logic [15:0] v,
                           logic ei, logic ed, logic ep, logic [15:0] en, string req);
      @(negedge clk);
      ptr_chk = chk; ptr_addr = a; ptr_write = wr; ptr_val = v;
      #1;
      check(req, 32'({ainc, adec, adj_pre}), 32'({ei, ed, ep}));
      check(req, 32'(ptr_next), 32'(en));
   endtask

   initial begin
      // R1: reset with boot ROM fitted, then without
      do_reset(1'b1);
      bank_val[0] = 8'hFF;
      io_read(0, "R1 rom bank0");
      check("R1 addr reset", 32'(addr_out), 32'h0);
      do_reset(1'b0);
      bank_val[0] = 8'h00;
      io_read(0, "R1 no-rom bank0");
      check("R1 addr reset", 32'(addr_out), 32'h0);

      // R6: program every bank register through I/O, read back
      for (int k = 0; k < 8; k++) io_write(k, 8'hA0 + 8'(k * 17));
      for (int k = 0; k < 8; k++) io_read(k, "R6 readback");
      @(negedge clk);
      io_sel = 3'd3; io_rd = 1'b0;
      #1 check("R6 idle rdata", 32'(io_rdata), 32'h0);

      // R2..R4: priority of enables
      load(1, 1, 1, 1, 6, 16'h1234, 0, "R2 fetch wins");
      load(1, 0, 0, 0, 3, 16'hBEEF, 0, "R2 fetch alone");
      load(0, 1, 1, 1, 6, 16'h0042, 1, "R3 zpage over stack");
      load(0, 0, 1, 1, 6, 16'hFFFE, 2, "R3 stack over index");
      load(0, 0, 0, 1, 5, 16'h0777, 5, "R4 index bank5");
      load(0, 0, 0, 1, 7, 16'h8000, 7, "R4 index bank7");
      load(0, 0, 0, 0, 4, 16'h5555, 0, "R4 default bank0");

      // R5: no load -> address holds
      @(negedge clk);
      ofs = 16'hDEAD; en_stack = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R5 hold", 32'(addr_out), 32'({bank_val[0], 16'h5555}));
      en_stack = 1'b0;

      // R6 + R5: rewrite bank 2, then use it
      io_write(2, 8'h3C);
      load(0, 0, 1, 0, 0, 16'h0100, 2, "R6 new bank2 used");

      // R7: pointer classes
      classify(1, 16'h0100, 0, 16'h1234, 0, 0, 0, 16'h1234, "R7 plain");
      classify(1, 16'h0141, 0, 16'h1234, 1, 0, 0, 16'h1235, "R7 autoinc");
      classify(1, 16'h01BF, 1, 16'h1234, 0, 1, 0, 16'h1233, "R7 autodec");
      classify(1, 16'h01C2, 1, 16'h2000, 1, 0, 0, 16'h2001, "R7 stack write");
      classify(1, 16'h01C2, 0, 16'h2000, 0, 1, 1, 16'h1FFF, "R7 stack read");
      // R8: outside the band or not a pointer access
      classify(1, 16'h0040, 0, 16'h0010, 0, 0, 0, 16'h0010, "R8 low page");
      classify(1, 16'h00FF, 1, 16'h0010, 0, 0, 0, 16'h0010, "R8 top of page0");
      classify(1, 16'h0240, 0, 16'h0010, 0, 0, 0, 16'h0010, "R8 upper normal");
      classify(1, 16'h03C0, 1, 16'h0010, 0, 0, 0, 16'h0010, "R8 upper stack-like");
      classify(0, 16'h0141, 0, 16'h0010, 0, 0, 0, 16'h0010, "R8 chk low");
      // R9: wrap within the bank; R10 covered by every flag check above
      classify(1, 16'h0147, 0, 16'hFFFF, 1, 0, 0, 16'h0000, "R9 inc wrap");
      classify(1, 16'h0187, 0, 16'h0000, 0, 1, 0, 16'hFFFF, "R9 dec wrap");
      classify(1, 16'h01FF, 0, 16'h0000, 0, 1, 1, 16'hFFFF, "R10 stack read wrap");

      @(negedge clk);
      ptr_chk = 1'b0;
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R5 actual=%0d pending expected=0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule